// File: doc/BRIEF.md
# Reset Fanout and Power-Good Delay

This block spreads one active-low hardware reset across three active-low reset outputs: a slot reset, a device reset and a disk reset. Each output can hold its release back by a shared delay of one to four timebase units, and each can be pulsed low on request from a register bit that clears itself when the pulse is over. The block also forms a combined power-good signal from two power-good inputs and drives a power-good output with an optional release delay of one to four longer units and its own self-clearing pulse request.

The control bytes live in a register bank outside the block and arrive on two plain input buses. When a pulse ends, the block raises a one-cycle clear strobe for the matching request bit, and the register bank clears that bit on the same clock edge. A single-cycle tick from a shared millisecond timebase drives all delays and pulse widths. The delays act only on release: a low input pulls its output low at once and cancels any release count in progress. Every output is the AND of the input, the release timer (when enabled) and the inverse of the pulse generator, so a pulse that overlaps a hardware reset lengthens the low time.

Top module: `rfp_reset_fanout`

## Requirements
- R1: With its delay enable at 0, each reset output (index 0 slot, 1 device, 2 disk) equals `rst_in_n` in the same cycle, unless a pulse is active on it.
- R2: With its delay enable at 1, a reset output stays low after `rst_in_n` rises until (sel+1)*RST_UNIT ticks have been counted on clock edges while the input is high, where sel is `rst_ctl_i[1:0]`; it rises right after the edge that counts the last tick.
- R3: When `rst_in_n` goes low, every reset output is low in the same cycle, and a release count in progress restarts from zero when the input rises again.
- R4: The delay enables are independent: `rst_ctl_i` bit 4 serves the slot output, bit 3 the device output, bit 2 the disk output.
- R5: A 1 in `rst_ctl_i` bit 7, 6 or 5 (slot, device, disk) starts a low pulse on the next edge; it lasts until (sel+1)*RST_UNIT ticks have been counted; at the edge that ends it, the matching bit of `rst_clr_o` goes high for exactly one cycle, and no new pulse starts in that cycle.
- R6: A reset output is low whenever the hardware path or its pulse generator holds it low; a pulse overlapping a hardware reset keeps the output low after the input rises.
- R7: The combined power-good is `pg_in_a` AND `pg_in_b`; `pg_out` is low in the same cycle in which either input is low.
- R8: `pg_ctl_i` bit 2 enables the power-good release delay of (sel+1)*PG_UNIT ticks, sel being `pg_ctl_i[1:0]`; at 0, `pg_out` follows the combined input.
- R9: A 1 in `pg_ctl_i` bit 7 pulls `pg_out` low from the next edge for (sel+1)*PG_UNIT ticks, then raises `pg_clr_o` for one cycle.
- R10: During and right after reset, all reset outputs and `pg_out` are low while their inputs are low, and both clear strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | One-cycle pulse per timebase unit (1 ms) |
| rst_in_n | input | 1 | Active-low hardware reset to fan out |
| pg_in_a | input | 1 | First power-good input |
| pg_in_b | input | 1 | Second power-good input |
| rst_ctl_i | input | 8 | Reset control byte: pulse requests [7:5], delay enables [4:2], delay select [1:0] |
| pg_ctl_i | input | 8 | Power-good control byte: pulse request [7], delay enable [2], delay select [1:0] |
| rst_out_n | output | 3 | Active-low reset outputs: [0] slot, [1] device, [2] disk |
| rst_clr_o | output | 3 | One-cycle clear strobes for `rst_ctl_i` bits 7, 6, 5 (index 0, 1, 2) |
| pg_out | output | 1 | Power-good output |
| pg_clr_o | output | 1 | One-cycle clear strobe for `pg_ctl_i` bit 7 |

## Verification
The bench builds the block with RST_UNIT at 2 and PG_UNIT at 3 instead of 1 and 100, so every one of the four power-good delay settings ends within a few dozen cycles and the reset delays span several ticks rather than one, which separates an off-by-one tick count from a correct one. With a tick on every cycle the release and pulse edges land on exact, hand-counted cycles; a later phase with a tick every third cycle and changing inputs and control bytes drives restarts, overlapping pulses and mid-count select changes.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

  // Number of fanned-out reset outputs; the control byte layout fixes it at three.
  localparam int unsigned NUM_RST = 3;

  // Bit positions inside the reset control byte.
  localparam int unsigned RST_PULSE_MSB = 7;  // slot pulse; device and disk follow downward
  localparam int unsigned RST_EN_MSB    = 4;  // slot delay enable; device and disk follow downward

  // Bit positions inside the power-good control byte.
  localparam int unsigned PG_PULSE_BIT = 7;
  localparam int unsigned PG_EN_BIT    = 2;

  // Ticks to count for a two-bit select: (sel+1) units.
  function automatic int unsigned span_ticks(input logic [1:0] sel, input int unsigned unit);
    return (32'(sel) + 32'd1) * unit;
  endfunction

  // Counter width able to hold the longest span.
  function automatic int unsigned span_width(input int unsigned unit);
    return $clog2(4 * unit + 1);
  endfunction

endpackage

// File: rtl/rfp_release_timer.sv
module rfp_release_timer #(
  parameter int unsigned UNIT = 1,
  localparam int unsigned CW  = rfp_pkg::span_width(UNIT)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       level_i,
  input  logic [1:0] sel_i,
  output logic       done_o
);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [CW-1:0] tgt;
  logic [CW-1:0] cnt_nx;

  assign tgt    = CW'(rfp_pkg::span_ticks(sel_i, UNIT));
  assign cnt_nx = cnt_q + 1'b1;

  // Counts ticks while the level is high; any low level restarts the count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!level_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q && tick_i) begin
      if (cnt_nx >= tgt) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_nx;
      end
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/rfp_sw_pulse.sv
module rfp_sw_pulse #(
  parameter int unsigned UNIT = 1,
  localparam int unsigned CW  = rfp_pkg::span_width(UNIT)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic [1:0] sel_i,
  output logic       low_o,
  output logic       clr_o
);

  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          clr_q;
  logic [CW-1:0] tgt;
  logic [CW-1:0] cnt_nx;

  assign tgt    = CW'(rfp_pkg::span_ticks(sel_i, UNIT));
  assign cnt_nx = cnt_q + 1'b1;

  // The request bit is still set while the clear strobe is out, so a start
  // is blocked in that cycle; the register drops the bit on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (act_q) begin
        if (tick_i) begin
          if (cnt_nx >= tgt) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            clr_q <= 1'b1;
          end else begin
            cnt_q <= cnt_nx;
          end
        end
      end else if (req_i && !clr_q) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end
    end
  end

  assign low_o = act_q;
  assign clr_o = clr_q;

endmodule

// File: rtl/rfp_reset_fanout.sv
module rfp_reset_fanout #(
  parameter int unsigned RST_UNIT = 1,
  parameter int unsigned PG_UNIT  = 100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick_i,
  input  logic                         rst_in_n,
  input  logic                         pg_in_a,
  input  logic                         pg_in_b,
  input  logic [7:0]                   rst_ctl_i,
  input  logic [7:0]                   pg_ctl_i,
  output logic [rfp_pkg::NUM_RST-1:0]  rst_out_n,
  output logic [rfp_pkg::NUM_RST-1:0]  rst_clr_o,
  output logic                         pg_out,
  output logic                         pg_clr_o
);

  import rfp_pkg::*;

  logic [1:0] rst_sel;
  logic [1:0] pg_sel;
  logic       pg_comb;

  assign rst_sel = rst_ctl_i[1:0];
  assign pg_sel  = pg_ctl_i[1:0];
  assign pg_comb = pg_in_a & pg_in_b;

  // Reset channels: index 0 slot, 1 device, 2 disk.
  for (genvar gi = 0; gi < NUM_RST; gi++) begin : g_ch
    logic rel_done;
    logic pulse_low;
    logic dly_en;

    assign dly_en = rst_ctl_i[RST_EN_MSB - gi];

    rfp_release_timer #(.UNIT(RST_UNIT)) u_rel (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .level_i (rst_in_n),
      .sel_i   (rst_sel),
      .done_o  (rel_done)
    );

    rfp_sw_pulse #(.UNIT(RST_UNIT)) u_pls (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .req_i  (rst_ctl_i[RST_PULSE_MSB - gi]),
      .sel_i  (rst_sel),
      .low_o  (pulse_low),
      .clr_o  (rst_clr_o[gi])
    );

    assign rst_out_n[gi] = rst_in_n & (rel_done | ~dly_en) & ~pulse_low;
  end

  // Power-good path.
  logic pg_done;
  logic pg_low;

  rfp_release_timer #(.UNIT(PG_UNIT)) u_pg_rel (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .level_i (pg_comb),
    .sel_i   (pg_sel),
    .done_o  (pg_done)
  );

  rfp_sw_pulse #(.UNIT(PG_UNIT)) u_pg_pls (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .req_i  (pg_ctl_i[PG_PULSE_BIT]),
    .sel_i  (pg_sel),
    .low_o  (pg_low),
    .clr_o  (pg_clr_o)
  );

  assign pg_out = pg_comb & (pg_done | ~pg_ctl_i[PG_EN_BIT]) & ~pg_low;

endmodule

// File: rtl/rfp_reset_fanout_chk.sv
module rfp_reset_fanout_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       rst_in_n,
  input logic       pg_in_a,
  input logic       pg_in_b,
  input logic [7:0] rst_ctl_i,
  input logic [7:0] pg_ctl_i,
  input logic [2:0] rst_out_n,
  input logic [2:0] rst_clr_o,
  input logic       pg_out,
  input logic       pg_clr_o
);

  // R3: a low hardware reset reaches every output in the same cycle.
  a_r3_low_reaches_all: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_in_n |-> rst_out_n == 3'b000);

  // R2: a freshly released input cannot release a delayed slot output yet.
  a_r2_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_in_n) && rst_ctl_i[4]) |-> !rst_out_n[0]);

  // R5: each clear strobe lasts one cycle.
  a_r5_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_clr_o & $past(rst_clr_o)) == 3'b000);

  // R5: a clear strobe only follows a cycle in which that output was low.
  a_r5_clr_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    (|rst_clr_o) |-> ((rst_clr_o & $past(rst_out_n)) == 3'b000));

  // R7: power-good is low whenever either input is low.
  a_r7_pg_and: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_in_a && pg_in_b) |-> !pg_out);

  // R8: a delayed power-good is not released on the cycle its inputs come up.
  a_r8_pg_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pg_in_a && pg_in_b) && pg_ctl_i[2]) |-> !pg_out);

  // R9: the power-good clear strobe follows a low pulse and lasts one cycle.
  a_r9_pg_clr_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    pg_clr_o |-> ($past(!pg_out) && !$past(pg_clr_o)));

endmodule

bind rfp_reset_fanout rfp_reset_fanout_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .rst_in_n  (rst_in_n),
  .pg_in_a   (pg_in_a),
  .pg_in_b   (pg_in_b),
  .rst_ctl_i (rst_ctl_i),
  .pg_ctl_i  (pg_ctl_i),
  .rst_out_n (rst_out_n),
  .rst_clr_o (rst_clr_o),
  .pg_out    (pg_out),
  .pg_clr_o  (pg_clr_o)
);

// File: tb/rfp_reset_fanout_test.sv
`timescale 1ns/1ps
module rfp_reset_fanout_test;

  localparam int RU = 2;
  localparam int PU = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rin = 1'b0;
  logic       pga = 1'b0;
  logic       pgb = 1'b0;
  logic [7:0] rst_ctl = 8'h03;
  logic [7:0] pg_ctl = 8'h07;
  logic [2:0] rst_out_n;
  logic [2:0] rst_clr;
  logic       pg_out;
  logic       pg_clr;

  int checks = 0;
  int fails = 0;
  int tick_mode = 0;
  int cyc = 0;
  bit finished = 0;
  string cur_req = "R10";

  rfp_reset_fanout #(.RST_UNIT(RU), .PG_UNIT(PU)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rst_in_n(rin),
    .pg_in_a(pga), .pg_in_b(pgb), .rst_ctl_i(rst_ctl), .pg_ctl_i(pg_ctl),
    .rst_out_n(rst_out_n), .rst_clr_o(rst_clr), .pg_out(pg_out), .pg_clr_o(pg_clr)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  // ---------------- behavioural reference ----------------
  int  r_el[3];
  bit  r_done[3];
  bit  p_act[3];
  int  p_cnt[3];
  bit  p_clr[3];
  int  g_el;
  bit  g_done;
  bit  g_act;
  int  g_cnt;
  bit  g_clr;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        r_el[i] = 0; r_done[i] = 0; p_act[i] = 0; p_cnt[i] = 0; p_clr[i] = 0;
      end
      g_el = 0; g_done = 0; g_act = 0; g_cnt = 0; g_clr = 0;
    end else begin
      int rw;
      int gw;
      bit nclr;
      rw = (rst_ctl[1:0] + 1) * RU;
      gw = (pg_ctl[1:0] + 1) * PU;
      for (int i = 0; i < 3; i++) begin
        if (!rin) begin
          r_el[i] = 0; r_done[i] = 0;
        end else if (!r_done[i] && tick) begin
          r_el[i]++;
          if (r_el[i] >= rw) begin r_done[i] = 1; r_el[i] = 0; end
        end
        nclr = 0;
        if (p_act[i]) begin
          if (tick) begin
            p_cnt[i]++;
            if (p_cnt[i] >= rw) begin p_act[i] = 0; p_cnt[i] = 0; nclr = 1; end
          end
        end else if (rst_ctl[7-i] && !p_clr[i]) begin
          p_act[i] = 1; p_cnt[i] = 0;
        end
        if (p_clr[i]) rst_ctl[7-i] <= 1'b0;
        p_clr[i] = nclr;
      end
      if (!(pga && pgb)) begin
        g_el = 0; g_done = 0;
      end else if (!g_done && tick) begin
        g_el++;
        if (g_el >= gw) begin g_done = 1; g_el = 0; end
      end
      nclr = 0;
      if (g_act) begin
        if (tick) begin
          g_cnt++;
          if (g_cnt >= gw) begin g_act = 0; g_cnt = 0; nclr = 1; end
        end
      end else if (pg_ctl[7] && !g_clr) begin
        g_act = 1; g_cnt = 0;
      end
      if (g_clr) pg_ctl[7] <= 1'b0;
      g_clr = nclr;
    end
  end

  // Tick source: 0 none, 1 every cycle, 2 every third cycle.
  always @(posedge clk) begin
    #2;
    tick = (tick_mode == 1) ? 1'b1 : ((tick_mode == 2) ? (cyc % 3 == 0) : 1'b0);
  end

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [2:0] er;
      logic [2:0] ec;
      for (int i = 0; i < 3; i++) begin
        er[i] = rin & (rst_ctl[4-i] ? r_done[i] : 1'b1) & ~p_act[i];
        ec[i] = p_clr[i];
      end
      chk({cur_req, " rst_out_n"}, 32'(rst_out_n), 32'(er));
      chk({cur_req, " rst_clr"}, 32'(rst_clr), 32'(ec));
      chk({cur_req, " pg_out"}, 32'(pg_out),
          32'(pga & pgb & (pg_ctl[2] ? g_done : 1'b1) & ~g_act));
      chk({cur_req, " pg_clr"}, 32'(pg_clr), 32'(g_clr));
    end
  end

  // Watchdog.
  initial begin
    #1500000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    step(3);
    #3;
    chk("R10 rst_out_n in reset", 32'(rst_out_n), 0);
    chk("R10 pg_out in reset", 32'(pg_out), 0);
    chk("R10 clears in reset", 32'({rst_clr, pg_clr}), 0);
    step(1);
    rst_n = 1'b1;
    #3;
    chk("R10 rst_out_n after reset", 32'(rst_out_n), 0);
    chk("R10 clears after reset", 32'({rst_clr, pg_clr}), 0);

    // R1: no delay, outputs follow input at once
    cur_req = "R1";
    step(1);
    rst_ctl = 8'h03;
    rin = 1'b1;
    #3;
    chk("R1 follow high", 32'(rst_out_n), 32'h7);
    step(1);
    rin = 1'b0;
    #3;
    chk("R3 follow low", 32'(rst_out_n), 0);

    // R2: all delays on, sel 01 -> 4 ticks, tick every cycle
    cur_req = "R2";
    tick_mode = 1;
    step(1);
    rst_ctl = 8'h1D;
    step(1);
    rin = 1'b1;
    #3;
    chk("R2 held at rise", 32'(rst_out_n), 0);
    step(3);
    #3;
    chk("R2 held after 3 ticks", 32'(rst_out_n), 0);
    step(1);
    #3;
    chk("R2 released after 4 ticks", 32'(rst_out_n), 32'h7);

    // R3: a low blip restarts the count
    cur_req = "R3";
    rin = 1'b0;
    step(1);
    rin = 1'b1;
    step(2);
    rin = 1'b0;
    #3;
    chk("R3 low mid count", 32'(rst_out_n), 0);
    step(1);
    rin = 1'b1;
    step(3);
    #3;
    chk("R3 restarted count holds", 32'(rst_out_n), 0);
    step(1);
    #3;
    chk("R3 restarted count releases", 32'(rst_out_n), 32'h7);

    // R4: device delay only
    cur_req = "R4";
    rst_ctl = 8'h09;
    rin = 1'b0;
    step(1);
    rin = 1'b1;
    #3;
    chk("R4 only device held", 32'(rst_out_n), 32'h5);
    step(4);
    #3;
    chk("R4 device released", 32'(rst_out_n), 32'h7);

    // R5: slot pulse, sel 00 -> 2 ticks
    cur_req = "R5";
    rst_ctl = 8'h00;
    step(1);
    rst_ctl = 8'h80;
    step(1);
    #3;
    chk("R5 slot pulse low", 32'(rst_out_n), 32'h6);
    step(2);
    #3;
    chk("R5 slot pulse ended", 32'(rst_out_n), 32'h7);
    chk("R5 slot clear strobe", 32'(rst_clr), 32'h1);
    step(1);
    #3;
    chk("R5 strobe one cycle", 32'(rst_clr), 0);
    chk("R5 request bit cleared", 32'(rst_ctl[7]), 0);
    step(3);
    #3;
    chk("R5 no retrigger", 32'(rst_out_n), 32'h7);
    rst_ctl = 8'h60;
    step(1);
    #3;
    chk("R5 device and disk pulse", 32'(rst_out_n), 32'h1);
    step(4);

    // R6: pulse overlapping a hardware reset, sel 11 -> 8 ticks
    cur_req = "R6";
    rst_ctl = 8'h83;
    step(1);
    rin = 1'b0;
    step(1);
    rin = 1'b1;
    #3;
    chk("R6 pulse keeps slot low", 32'(rst_out_n), 32'h6);
    step(10);

    // R7: power-good AND, no delay
    cur_req = "R7";
    pg_ctl = 8'h00;
    pga = 1'b1;
    pgb = 1'b0;
    #3;
    chk("R7 one input low", 32'(pg_out), 0);
    step(1);
    pgb = 1'b1;
    #3;
    chk("R7 both high", 32'(pg_out), 1);
    step(1);
    pga = 1'b0;
    #3;
    chk("R7 first input low", 32'(pg_out), 0);

    // R8: delay enabled, sel 01 -> 6 ticks
    cur_req = "R8";
    step(1);
    pg_ctl = 8'h05;
    step(1);
    pga = 1'b1;
    step(5);
    #3;
    chk("R8 held after 5 ticks", 32'(pg_out), 0);
    step(1);
    #3;
    chk("R8 released after 6 ticks", 32'(pg_out), 1);

    // R9: power-good pulse, sel 00 -> 3 ticks
    cur_req = "R9";
    pg_ctl = 8'h80;
    step(1);
    #3;
    chk("R9 pulse low", 32'(pg_out), 0);
    step(2);
    #3;
    chk("R9 pulse still low", 32'(pg_out), 0);
    step(1);
    #3;
    chk("R9 pulse ended", 32'(pg_out), 1);
    chk("R9 clear strobe", 32'(pg_clr), 1);
    step(1);
    #3;
    chk("R9 request bit cleared", 32'(pg_ctl[7]), 0);

    // Mixed traffic checked by the reference every cycle (R6 and others)
    cur_req = "R6";
    tick_mode = 2;
    for (int k = 0; k < 3000; k++) begin
      step(1);
      if ($urandom_range(0, 15) == 0) rin = ~rin;
      if ($urandom_range(0, 19) == 0) pga = ~pga;
      if ($urandom_range(0, 19) == 0) pgb = ~pgb;
      if ($urandom_range(0, 40) == 0) rst_ctl = 8'($urandom);
      if ($urandom_range(0, 60) == 0) pg_ctl = 8'($urandom);
    end
    step(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule